// File: doc/BRIEF.md
# Oversampled SPI Frame Receiver

This block receives fixed-length 64-bit frames from an external SPI controller and turns each completed frame into four parallel fields: two 3-bit select codes and two 29-bit values zero-extended to 32 bits. The SPI clock, serial data and active-low chip select pins are never used as clocks. Each one is treated as an asynchronous input and passes through a two-flop synchronizer clocked by the system clock. Edge detectors on the synchronized lines produce single-cycle pulses, and all further logic runs on the system clock. The system clock must run at least four times faster than the SPI clock.

A two-state controller sequences the frame. In `RX_IDLE` the block waits. The START transition, taken on a falling edge of the synchronized select, clears the bit counter and enters `RX_SHIFT`. In `RX_SHIFT` each rising SPI clock edge shifts one bit in at bit 0, and the counter advances, stopping at its maximum value. The FINISH transition, taken on a rising edge of the synchronized select, returns to `RX_IDLE`. If exactly 64 bits arrived, the fields are latched and `frame_valid_o` pulses. Otherwise `frame_error_o` pulses and the outputs keep their previous values.

Top module: `spi_frame_rx`

## Requirements
- R1: While synchronous active-high `rst` is asserted and on the cycle after it is released, all four field outputs are zero and neither `frame_valid_o` nor `frame_error_o` is high.
- R2: Bits are captured only on rising edges of `spi_sck_i` while `spi_cs_n_i` is low. The first bit received lands in frame bit 63 and the last in bit 0.
- R3: The field split is `sel_hi_o` = frame bits 63..61, `word_a_o[28:0]` = bits 60..32, `sel_lo_o` = bits 31..29 and `word_b_o[28:0]` = bits 28..0.
- R4: Bits 31..29 of `word_a_o` and of `word_b_o` are always zero.
- R5: The field outputs change only on the cycle in which `frame_valid_o` is high. That happens once per transaction, in the cycle after the synchronized select returns high, and only when exactly 64 bits were received. The pulse lasts one cycle.
- R6: A transaction with fewer than 64 bits raises a one-cycle `frame_error_o` and leaves all field outputs unchanged.
- R7: A transaction with more than 64 bits raises a one-cycle `frame_error_o` and leaves all field outputs unchanged.
- R8: SPI clock edges while `spi_cs_n_i` is high change no output and raise no pulse. A following valid frame is still decoded correctly.
- R9: `frame_valid_o` and `frame_error_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the SPI clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck_i | input | 1 | SPI clock from the controller, asynchronous |
| spi_mosi_i | input | 1 | Serial data from the controller, asynchronous |
| spi_cs_n_i | input | 1 | Active-low chip select, asynchronous |
| sel_hi_o | output | 3 | Upper select code |
| word_a_o | output | 32 | Upper value, zero-extended |
| sel_lo_o | output | 3 | Lower select code |
| word_b_o | output | 32 | Lower value, zero-extended |
| frame_valid_o | output | 1 | One-cycle pulse when new fields are latched |
| frame_error_o | output | 1 | One-cycle pulse on a wrong-length transaction |

## Verification
Four properties are checked on every cycle:
- the two status pulses never coincide;
- a valid pulse never lasts two cycles;
- the field outputs never change outside a valid pulse;
- each status pulse agrees with the bit count that the counter held one cycle earlier.

Other behaviour can only be shown by the bench's scenarios, because it depends on what the controller actually sent. This covers bit ordering, the exact field boundaries, zero padding under all-ones frames, rejection of short and long transactions, and immunity to clock toggling while select is high.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;

    // Frame controller states
    typedef enum logic {
        RX_IDLE  = 1'b0,   // select high, waiting for START
        RX_SHIFT = 1'b1    // select low, collecting bits until FINISH
    } rx_state_e;

    localparam int SYNC_STAGES_DEF = 2;

endpackage

// File: rtl/spi_sync_chain.sv
module spi_sync_chain #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              d,
    output logic [STAGES-1:0] q
);

    // q[0] is the first flop, q[STAGES-1] the last
    always_ff @(posedge clk) begin
        if (rst) q <= {STAGES{RST_VAL}};
        else     q <= {q[STAGES-2:0], d};
    end

endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det (
    input  logic first_q,
    input  logic second_q,
    output logic rise,
    output logic fall
);

    // One system clock wide, since the chain shifts every cycle
    assign rise = first_q & ~second_q;
    assign fall = ~first_q & second_q;

endmodule

// File: rtl/spi_field_split.sv
module spi_field_split #(
    parameter int FRAME_BITS = 64,
    parameter int SEL_W      = 3,
    parameter int VAL_W      = 29,
    parameter int WORD_W     = 32
) (
    input  logic [FRAME_BITS-1:0] frame,
    output logic [SEL_W-1:0]      sel_hi,
    output logic [WORD_W-1:0]     word_a,
    output logic [SEL_W-1:0]      sel_lo,
    output logic [WORD_W-1:0]     word_b
);

    localparam int HALF = FRAME_BITS / 2;

    assign sel_hi = frame[FRAME_BITS-1 -: SEL_W];
    assign word_a = WORD_W'(frame[HALF +: VAL_W]);
    assign sel_lo = frame[HALF-1 -: SEL_W];
    assign word_b = WORD_W'(frame[0 +: VAL_W]);

endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
    import spi_rx_pkg::*;
#(
    parameter int FRAME_BITS  = 64,
    parameter int SEL_W       = 3,
    parameter int VAL_W       = 29,
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck_i,
    input  logic              spi_mosi_i,
    input  logic              spi_cs_n_i,
    output logic [SEL_W-1:0]  sel_hi_o,
    output logic [WORD_W-1:0] word_a_o,
    output logic [SEL_W-1:0]  sel_lo_o,
    output logic [WORD_W-1:0] word_b_o,
    output logic              frame_valid_o,
    output logic              frame_error_o
);

    localparam int               CNT_W    = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    // ---------------- synchronizers ----------------
    logic [SYNC_STAGES-1:0] sck_q, mosi_q, cs_q;

    spi_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
        .clk(clk), .rst(rst), .d(spi_sck_i), .q(sck_q)
    );
    spi_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
        .clk(clk), .rst(rst), .d(spi_mosi_i), .q(mosi_q)
    );
    spi_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst(rst), .d(spi_cs_n_i), .q(cs_q)
    );

    // ---------------- edge detection ----------------
    logic sck_rise, sck_fall_unused;
    logic cs_rise, cs_fall;

    spi_edge_det u_edge_sck (
        .first_q(sck_q[SYNC_STAGES-2]), .second_q(sck_q[SYNC_STAGES-1]),
        .rise(sck_rise), .fall(sck_fall_unused)
    );
    spi_edge_det u_edge_cs (
        .first_q(cs_q[SYNC_STAGES-2]), .second_q(cs_q[SYNC_STAGES-1]),
        .rise(cs_rise), .fall(cs_fall)
    );

    wire cs_active = ~cs_q[SYNC_STAGES-2];
    // Data held for half an SPI period, so the last stage is stable at the edge pulse
    wire mosi_bit  = mosi_q[SYNC_STAGES-1];

    // ---------------- field split ----------------
    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      bit_cnt;
    logic [SEL_W-1:0]      nx_sel_hi, nx_sel_lo;
    logic [WORD_W-1:0]     nx_word_a, nx_word_b;

    spi_field_split #(
        .FRAME_BITS(FRAME_BITS), .SEL_W(SEL_W), .VAL_W(VAL_W), .WORD_W(WORD_W)
    ) u_split (
        .frame(shreg),
        .sel_hi(nx_sel_hi), .word_a(nx_word_a),
        .sel_lo(nx_sel_lo), .word_b(nx_word_b)
    );

    // ---------------- controller ----------------
    rx_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:  if (cs_fall) state_nx = RX_SHIFT;   // START
            RX_SHIFT: if (cs_rise) state_nx = RX_IDLE;    // FINISH
            default:  state_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= RX_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg         <= '0;
            bit_cnt       <= '0;
            sel_hi_o      <= '0;
            word_a_o      <= '0;
            sel_lo_o      <= '0;
            word_b_o      <= '0;
            frame_valid_o <= 1'b0;
            frame_error_o <= 1'b0;
        end else begin
            frame_valid_o <= 1'b0;
            frame_error_o <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (cs_fall) bit_cnt <= '0;
                end
                RX_SHIFT: begin
                    if (sck_rise && cs_active) begin
                        shreg <= {shreg[FRAME_BITS-2:0], mosi_bit};
                        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (cs_rise) begin
                        if (bit_cnt == CNT_FULL) begin
                            sel_hi_o      <= nx_sel_hi;
                            word_a_o      <= nx_word_a;
                            sel_lo_o      <= nx_sel_lo;
                            word_b_o      <= nx_word_b;
                            frame_valid_o <= 1'b1;
                        end else begin
                            frame_error_o <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/spi_frame_rx_chk.sv
module spi_frame_rx_chk #(
    parameter int SEL_W  = 3,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 7,
    parameter int FULL   = 64
) (
    input logic              clk,
    input logic              rst,
    input logic [SEL_W-1:0]  sel_hi_o,
    input logic [WORD_W-1:0] word_a_o,
    input logic [SEL_W-1:0]  sel_lo_o,
    input logic [WORD_W-1:0] word_b_o,
    input logic              frame_valid_o,
    input logic              frame_error_o,
    input logic [CNT_W-1:0]  bit_cnt
);

    wire [2*SEL_W+2*WORD_W-1:0] fields = {sel_hi_o, word_a_o, sel_lo_o, word_b_o};

    // R9
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(frame_valid_o && frame_error_o));

    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid_o |=> !frame_valid_o);

    // R5
    fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fields != $past(fields)) |-> frame_valid_o);

    // R5
    valid_count_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid_o |-> ($past(bit_cnt) == CNT_W'(FULL)));

    // R6
    error_count_chk: assert property (@(posedge clk) disable iff (rst)
        frame_error_o |-> ($past(bit_cnt) != CNT_W'(FULL)));

endmodule

bind spi_frame_rx spi_frame_rx_chk #(
    .SEL_W(SEL_W), .WORD_W(WORD_W), .CNT_W(CNT_W), .FULL(FRAME_BITS)
) u_chk (
    .clk(clk), .rst(rst),
    .sel_hi_o(sel_hi_o), .word_a_o(word_a_o),
    .sel_lo_o(sel_lo_o), .word_b_o(word_b_o),
    .frame_valid_o(frame_valid_o), .frame_error_o(frame_error_o),
    .bit_cnt(bit_cnt)
);

// File: tb/tb_spi_frame_rx.sv
module tb_spi_frame_rx;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SPI   = 4;   // SPI clock = system clock / 8
    localparam int N_VEC      = 6;
    localparam logic [63:0] FRAMES [N_VEC] = '{
        64'hFFFF_FFFF_FFFF_FFFF,
        64'h0000_0000_0000_0000,
        64'hA5A5_5A5A_C3C3_3C3C,
        64'h8000_0000_0000_0001,
        64'h1234_5678_9ABC_DEF0,
        64'hE000_0000_2000_0000
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic [2:0]  sel_hi, sel_lo;
    logic [31:0] word_a, word_b;
    logic        fvalid, ferror;

    int tests = 0, fails = 0;
    int n_valid = 0, n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_frame_rx dut (
        .clk(clk), .rst(rst),
        .spi_sck_i(sck), .spi_mosi_i(mosi), .spi_cs_n_i(cs_n),
        .sel_hi_o(sel_hi), .word_a_o(word_a),
        .sel_lo_o(sel_lo), .word_b_o(word_b),
        .frame_valid_o(fvalid), .frame_error_o(ferror)
    );

    always @(negedge clk) begin
        if (fvalid) n_valid++;
        if (ferror) n_err++;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic spi_send(input logic [63:0] v, input int nbits);
        @(negedge clk) cs_n = 1'b0;
        repeat (2*HALF_SPI) @(negedge clk);
        for (int k = 0; k < nbits; k++) begin
            mosi = (k < 64) ? v[63-k] : 1'b0;
            repeat (HALF_SPI) @(negedge clk);
            sck = 1'b1;
            repeat (HALF_SPI) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF_SPI) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic chk_fields(input string req, input logic [63:0] f);
        chk(req, 64'(sel_hi), 64'(f[63:61]));
        chk(req, 64'(word_a), {35'd0, f[60:32]});
        chk(req, 64'(sel_lo), 64'(f[31:29]));
        chk(req, 64'(word_b), {35'd0, f[28:0]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] last;
        int v0, e0;
        repeat (5) @(negedge clk);
        // R1: outputs during reset
        chk("R1", {sel_hi, word_a, sel_lo, word_b, fvalid, ferror}, '0);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk("R1", {sel_hi, word_a, sel_lo, word_b, fvalid, ferror}, '0);
        chk("R1", 64'(n_valid + n_err), 64'd0);

        // R2 R3 R4 R5: table of frames
        for (int i = 0; i < N_VEC; i++) begin
            v0 = n_valid; e0 = n_err;
            spi_send(FRAMES[i], 64);
            chk_fields("R2 R3", FRAMES[i]);
            chk("R4", {32'(word_a[31:29]), 32'(word_b[31:29])}, 64'd0);
            chk("R5", 64'(n_valid - v0), 64'd1);
            chk("R9", 64'(n_err - e0), 64'd0);
        end
        last = FRAMES[N_VEC-1];

        // R6: short frame
        v0 = n_valid; e0 = n_err;
        spi_send(64'h0F0F_0F0F_0F0F_0F0F, 40);
        chk("R6", 64'(n_err - e0), 64'd1);
        chk("R6", 64'(n_valid - v0), 64'd0);
        chk_fields("R6", last);

        // R7: long frame
        v0 = n_valid; e0 = n_err;
        spi_send(64'h5555_AAAA_5555_AAAA, 65);
        chk("R7", 64'(n_err - e0), 64'd1);
        chk("R7", 64'(n_valid - v0), 64'd0);
        chk_fields("R7", last);

        // R8: clock toggling with select high
        v0 = n_valid; e0 = n_err;
        for (int k = 0; k < 20; k++) begin
            mosi = k[0];
            repeat (HALF_SPI) @(negedge clk);
            sck = 1'b1;
            repeat (HALF_SPI) @(negedge clk);
            sck = 1'b0;
        end
        repeat (10) @(negedge clk);
        chk("R8", 64'(n_valid + n_err - v0 - e0), 64'd0);
        chk_fields("R8", last);
        spi_send(64'h6DB6_DB6D_B6DB_6DB6, 64);
        chk_fields("R8", 64'h6DB6_DB6D_B6DB_6DB6);
        chk("R8", 64'(n_valid - v0), 64'd1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule